// File: doc/BRIEF.md
# Nibble-Split CRC-16 Region Checksum Engine

This block computes a 16-bit checksum over a span of a byte-addressed store. A one-cycle start pulse carries a base address and a byte count. The engine then issues one read per cycle on a synchronous read port, pairs the returned bytes into big-endian 16-bit words, and folds each word into the checksum with a nibble-split XOR update. When the final byte has been folded in, it raises a one-cycle done strobe and holds the result on its output.

A typical use is to protect a parameter table. The engine scans the first 0xF8 bytes, and the caller writes the result back into the table. The store, the table layout and the write-back sit outside this block.

Top module: `crc16_scan`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_en_o` are 0 and `crc_o` reads 0xFFFF.
- R2: Each scan starts from 0xFFFF. A start with a byte count of 0 raises `done_o` on the cycle after the start edge, with `crc_o` = 0xFFFF, and issues no reads.
- R3: Bytes are paired into words as (byte at the lower address) << 8 | (byte at the next address).
- R4: When the byte count is odd, the final byte is folded in as the word {byte, 8'h00}.
- R5: Per word w, with p = crc ^ w, a = p[3:0] and b = p[7:4] ^ a, the new checksum is the 16-bit truncation of (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12).
- R6: A scan of N bytes issues exactly N reads, one per cycle on consecutive cycles. `rd_en_o` is first high in the cycle after the start edge. Addresses run from the base address upward by 1. Read data is taken one cycle after `rd_en_o`.
- R7: For N > 0, `done_o` is high for exactly one cycle, N+2 cycles after the start edge. `busy_o` is high from the start edge until `done_o` rises.
- R8: A start pulse while `busy_o` is high is ignored: the running scan's reads and result are unchanged.
- R9: While no accepted start occurs, `crc_o` holds its value after `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only when idle |
| base_addr_i | input | AW | Address of the first byte |
| byte_cnt_i | input | CW | Number of bytes to scan |
| rd_en_o | output | 1 | Read request to the store |
| rd_addr_o | output | AW | Byte address of the read |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion strobe |
| crc_o | output | 16 | Checksum result |

## Verification
The assertions assume that the store answers every read on the following cycle, and that the base address plus the byte count fits in the address width, so the read addresses never wrap. They also assume that start is a clean synchronous level sampled on the clock edge.

The bench drives start away from the edge, and its store model always returns data one cycle after a request. Counts are kept far below the address range. Start pulses during a scan are issued deliberately, to exercise the ignore rule.

// File: rtl/crc16_scan_pkg.sv
package crc16_scan_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/crc_addr_gen.sv
module crc_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          beat_valid_o,
  output logic          beat_last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          valid_q, last_q;

  assign rd_en_o      = (rem_q != '0);
  assign rd_addr_o    = addr_q;
  assign beat_valid_o = valid_q;
  assign beat_last_o  = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (load_i) begin
        addr_q <= base_i;
        rem_q  <= count_i;
      end else if (rd_en_o) begin
        addr_q <= addr_q + AW'(1);
        rem_q  <= rem_q - CW'(1);
      end
      // data returns one cycle after the request
      valid_q <= rd_en_o;
      last_q  <= rd_en_o && (rem_q == CW'(1));
    end
  end
endmodule

// File: rtl/crc_byte_pair.sv
module crc_byte_pair
  import crc16_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              beat_valid_i,
  input  logic              beat_last_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic              phase_q;
  logic [BYTE_W-1:0] hi_q;

  always_comb begin
    word_valid_o = 1'b0;
    word_o       = '0;
    if (beat_valid_i) begin
      if (phase_q) begin
        word_valid_o = 1'b1;
        word_o       = {hi_q, byte_i};
      end else if (beat_last_i) begin
        // odd tail: pad low half with zeros
        word_valid_o = 1'b1;
        word_o       = {byte_i, {BYTE_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (clear_i) begin
      phase_q <= 1'b0;
    end else if (beat_valid_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) hi_q <= byte_i;
    end
  end
endmodule

// File: rtl/crc_nib_update.sv
module crc_nib_update
  import crc16_scan_pkg::*;
(
  input  logic [WORD_W-1:0] crc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] crc_o
);
  logic [WORD_W-1:0] mix;
  logic [3:0]        lo_nib, hi_nib;

  assign mix    = crc_i ^ word_i;
  assign lo_nib = mix[3:0];
  assign hi_nib = mix[7:4] ^ lo_nib;

  assign crc_o = {8'h00, mix[15:8]}
               ^ {5'b0, lo_nib, 3'b0} ^ {lo_nib, 8'b0}
               ^ {12'b0, hi_nib} ^ {1'b0, hi_nib, 7'b0} ^ {hi_nib, 12'b0};
endmodule

// File: rtl/crc16_scan.sv
module crc16_scan
  import crc16_scan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [CW-1:0]     byte_cnt_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] crc_o
);
  logic              busy_q, done_q;
  logic [WORD_W-1:0] crc_q, crc_nxt;
  logic              accept, beat_valid, beat_last, word_valid;
  logic [WORD_W-1:0] word;

  assign accept = start_i && !busy_q;

  crc_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .base_i      (base_addr_i),
    .count_i     (byte_cnt_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .beat_valid_o(beat_valid),
    .beat_last_o (beat_last)
  );

  crc_byte_pair u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .beat_valid_i(beat_valid),
    .beat_last_i (beat_last),
    .byte_i      (rd_data_i),
    .word_valid_o(word_valid),
    .word_o      (word)
  );

  crc_nib_update u_upd (
    .crc_i (crc_q),
    .word_i(word),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      crc_q  <= CRC_SEED;
    end else begin
      done_q <= (accept && byte_cnt_i == '0) || (beat_valid && beat_last);
      if (accept) begin
        busy_q <= (byte_cnt_i != '0);
        crc_q  <= CRC_SEED;
      end else begin
        if (beat_valid && beat_last) busy_q <= 1'b0;
        if (word_valid) crc_q <= crc_nxt;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign crc_o  = crc_q;
endmodule

// File: rtl/crc16_scan_chk.sv
module crc16_scan_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [15:0]   crc_o
);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  busy_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o || done_o);
  // R6
  rd_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);
  // R6
  rd_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_addr_o == $past(rd_addr_o) + AW'(1));
  // R9
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(crc_o));
  // R8
  busy_start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !rd_en_o |=> !rd_en_o);
endmodule

bind crc16_scan crc16_scan_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rd_en_o  (rd_en_o),
  .rd_addr_o(rd_addr_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .crc_o    (crc_o)
);

// File: tb/crc16_scan_test.sv
module crc16_scan_test;
  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic          rd_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i = '0;
  logic          busy_o, done_o;
  logic [15:0]   crc_o;

  int n_tests = 0;
  int n_fail = 0;
  int mon_reads = 0;
  int mon_bad = 0;
  logic [AW-1:0] mon_exp = '0;
  logic [7:0] mem [0:255];

  always #10 clk_i = ~clk_i;

  crc16_scan #(.AW(AW), .CW(CW)) uut (.*);

  // store model: one-cycle synchronous read
  always @(posedge clk_i) if (rd_en_o) rd_data_i <= mem[rd_addr_o[7:0]];

  always @(negedge clk_i) if (rst_ni && rd_en_o) begin
    if (rd_addr_o !== mon_exp) mon_bad++;
    mon_exp = mon_exp + 1'b1;
    mon_reads++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] p, r;
    logic [3:0] a, b;
    p = c ^ w;
    a = p[3:0];
    b = p[7:4] ^ a;
    r = p >> 8;
    r = r ^ (16'(a) << 3) ^ (16'(a) << 8) ^ 16'(b) ^ (16'(b) << 7) ^ (16'(b) << 12);
    return r;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [AW-1:0] a, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i + 1 < n; i += 2)
      c = ref_step(c, {mem[8'(a + AW'(i))], mem[8'(a + AW'(i + 1))]});
    if (n % 2 == 1) c = ref_step(c, {mem[8'(a + AW'(n - 1))], 8'h00});
    return c;
  endfunction

  task automatic run_scan(input logic [AW-1:0] a, input int n, input bit inject, input string req);
    logic [15:0] exp, crc_at_done;
    int first_done, n_done, exp_k;
    exp = ref_crc(a, n);
    exp_k = (n == 0) ? 1 : n + 2;
    first_done = -1;
    n_done = 0;
    crc_at_done = '0;
    @(negedge clk_i);
    mon_exp = a;
    mon_reads = 0;
    mon_bad = 0;
    start_i = 1'b1;
    base_addr_i = a;
    byte_cnt_i = CW'(n);
    for (int k = 1; k <= n + 8; k++) begin
      @(negedge clk_i);
      if (k == 1) check({req, " R6 no read before start edge"}, 32'(busy_o), 32'(n != 0));
      if (done_o) begin
        n_done++;
        if (first_done < 0) begin first_done = k; crc_at_done = crc_o; end
      end
      // R8: pulse start with other parameters mid-scan
      if (inject && k == 2) begin
        start_i = 1'b1;
        base_addr_i = a + 16'd9;
        byte_cnt_i = CW'(n + 3);
      end else start_i = 1'b0;
    end
    check({req, " R7 done cycle"}, 32'(first_done), 32'(exp_k));
    check({req, " R7 done one cycle"}, 32'(n_done), 32'd1);
    check({req, " R5 checksum"}, 32'(crc_at_done), 32'(exp));
    check({req, " R6 read count"}, 32'(mon_reads), 32'(n));
    check({req, " R6 read addresses"}, 32'(mon_bad), 32'd0);
    check({req, " R9 result held"}, 32'(crc_o), 32'(crc_at_done));
    check({req, " R7 idle after"}, 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 rd_en", 32'(rd_en_o), 32'd0);
    check("R1 crc", 32'(crc_o), 32'hFFFF);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_scan(16'd5, 0, 1'b0, "R2 zero count");
    check("R2 seed", 32'(crc_o), 32'hFFFF);
    // R3: known pair 0x12,0x34 forms word 0x1234
    mem[100] = 8'h12; mem[101] = 8'h34;
    run_scan(16'd100, 2, 1'b0, "R3 pair");
    check("R3 word order", 32'(crc_o), 32'(ref_step(16'hFFFF, 16'h1234)));
    // R4: single byte padded to {byte, 00}
    mem[50] = 8'hA7;
    run_scan(16'd50, 1, 1'b0, "R4 one byte");
    check("R4 pad", 32'(crc_o), 32'(ref_step(16'hFFFF, 16'hA700)));
    run_scan(16'd3, 5, 1'b0, "R4 odd five");
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    run_scan(16'd0, 6, 1'b0, "R5 zeros");
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    run_scan(16'd0, 248, 1'b0, "R5 table span");
    run_scan(16'd20, 30, 1'b1, "R8 start while busy");
    run_scan(16'd40, 7, 1'b1, "R8 start while busy odd");
    for (int t = 0; t < 20; t++)
      run_scan(AW'($urandom_range(0, 180)), int'($urandom_range(0, 60)), t[0], "R5 random");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule